// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on independent clocks. A producer pushes a word on every write-clock edge where its active-low write enable is low and the buffer is not full. A consumer pops a word into a registered data output on every read-clock edge where its active-low read enable is low and the buffer is not empty. The two pointers cross between the domains as Gray codes through two-flop synchronizers.

Five active-low status flags describe how full the buffer is: empty, almost-empty, half-full, almost-full and full. The almost-empty distance `n` and the almost-full distance `m` come in on ports. Empty and almost-empty are registered in the read domain. Full, almost-full and half-full are registered in the write domain. A rewind strobe on the read side sends the read pointer back to physical location 0, so everything written since reset plays out again, followed by any later writes. Rewind is meant for use after no more than DEPTH writes since reset, with the write side idle around the strobe. DEPTH must be a power of two (default 1024 x 18).

Top module: `xclk_fifo`

## Requirements
- R1: A write happens only at a `wclk` edge where `wr_en_n` is 0 and `full_n` is 1. While `full_n` is 0 the write is dropped and the stored contents stay unchanged. `full_n` is 0 exactly when DEPTH words are held.
- R2: A read happens only at an `rclk` edge where `rd_en_n` is 0, `empty_n` is 1 and `rewind` is 0. When no read happens, `rd_data` keeps the last word read.
- R3: If `rd_en_n` is held at 0 while the buffer is empty, the first written word appears on `rd_data` at the `rclk` edge that follows the edge on which `empty_n` rises.
- R4: Once both clocks have run idle for a few cycles, `empty_n` is 0 exactly at occupancy 0, and `aempty_n` is 0 exactly when occupancy <= `ae_ofs`. Both flags change only on `rclk` edges.
- R5: Once settled, `half_n` is 0 exactly when occupancy > DEPTH/2. It changes only on `wclk` edges.
- R6: Once settled, `afull_n` is 0 exactly when occupancy + `af_ofs` >= DEPTH. It changes only on `wclk` edges, and it is 0 whenever `full_n` is 0.
- R7: While `rst_n` is 0 the buffer empties and `rd_data` is 0. `empty_n` and `aempty_n` are 0, and `half_n`, `afull_n` and `full_n` are 1.
- R8: Under concurrent traffic on unrelated clocks, words leave in the order they were accepted, with no loss and no duplication.
- R9: A `rewind` of 1 at an `rclk` edge sets the read pointer to location 0. Later reads return every word written since reset, in order, followed by words written after the rewind.
- R10: After a rewind, once settled, all five flags reflect the occupancy between the rewound read pointer and the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DW | Word to store |
| rd_en_n | input | 1 | Active-low read request |
| rd_data | output | DW | Registered output word |
| rewind | input | 1 | Read-clock strobe that returns the read pointer to location 0 |
| ae_ofs | input | AW+1 | Almost-empty distance n |
| af_ofs | input | AW+1 | Almost-full distance m |
| empty_n | output | 1 | 0 when empty (read domain) |
| aempty_n | output | 1 | 0 when occupancy <= n (read domain) |
| half_n | output | 1 | 0 when occupancy > DEPTH/2 (write domain) |
| afull_n | output | 1 | 0 when occupancy >= DEPTH - m (write domain) |
| full_n | output | 1 | 0 when DEPTH words are held (write domain) |

## Verification
The bench steps occupancy through every value from 0 to DEPTH and back, so that each flag is seen on both sides of its threshold. An off-by-one compare would flip a flag one word early or late. A wrong offset width would mis-set the almost flags when the offsets are 0. Writes are pushed while full and reads are pulled while empty. A design without the block would wrap a pointer, which shows up as lost or repeated words and as a changed `rd_data` on an empty buffer. Rewind is checked by replaying the stored words and then a word written afterwards. Random traffic on two clocks with unrelated periods exposes any Gray-code or synchronizer fault as out-of-order data or as a flag that claims data which is not there.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  // occupancy at or below the almost-empty distance
  function automatic logic ae_hit(input int unsigned occ, input int unsigned ofs);
    return occ <= ofs;
  endfunction

  // occupancy within the almost-full distance of the top
  function automatic logic af_hit(input int unsigned occ, input int unsigned ofs,
                                  input int unsigned depth);
    return (occ + ofs) >= depth;
  endfunction

  // occupancy strictly above half depth
  function automatic logic hf_hit(input int unsigned occ, input int unsigned depth);
    return occ > (depth / 2);
  endfunction

endpackage

// File: rtl/xfifo_gsync.sv
module xfifo_gsync #(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= gray_in;
      stage2_q <= stage1_q;
    end
  end

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign bin_out = gray_to_bin(stage2_q);
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
  parameter int DW = 18,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] store [WORDS];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/xfifo_wctl.sv
module xfifo_wctl
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int PW    = 11
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [PW-1:0] af_ofs,
  input  logic [PW-1:0] rptr_seen,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wocc,
  output logic          full_n,
  output logic          afull_n,
  output logic          half_n
);
  logic [PW-1:0] wptr_q, wptr_nxt, occ_nxt;

  assign wr_fire  = !wr_en_n && full_n;
  assign wptr_nxt = wptr_q + PW'(wr_fire);
  assign occ_nxt  = wptr_nxt - rptr_seen;
  assign waddr    = wptr_q[AW-1:0];
  assign wptr     = wptr_q;
  assign wocc     = wptr_q - rptr_seen;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      half_n  <= 1'b1;
    end else begin
      wptr_q  <= wptr_nxt;
      wgray   <= wptr_nxt ^ (wptr_nxt >> 1);
      full_n  <= (occ_nxt != PW'(DEPTH));
      afull_n <= !af_hit(32'(occ_nxt), 32'(af_ofs), DEPTH);
      half_n  <= !hf_hit(32'(occ_nxt), DEPTH);
    end
  end
endmodule

// File: rtl/xfifo_rctl.sv
module xfifo_rctl
  import xfifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 10,
  parameter int PW = 11
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          rewind,
  input  logic [PW-1:0] ae_ofs,
  input  logic [PW-1:0] wptr_seen,
  input  logic [DW-1:0] mem_q,
  output logic          rd_fire,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [PW-1:0] rptr,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_n
);
  logic [PW-1:0] rptr_q, rptr_nxt, occ_nxt;

  // rewind wins over a read in the same cycle
  assign rd_fire  = !rd_en_n && empty_n && !rewind;
  assign rptr_nxt = rewind ? '0 : rptr_q + PW'(rd_fire);
  assign occ_nxt  = wptr_seen - rptr_nxt;
  assign raddr    = rptr_q[AW-1:0];
  assign rptr     = rptr_q;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q   <= '0;
      rgray    <= '0;
      rd_data  <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rptr_q   <= rptr_nxt;
      rgray    <= rptr_nxt ^ (rptr_nxt >> 1);
      if (rd_fire) rd_data <= mem_q;
      empty_n  <= (occ_nxt != '0);
      aempty_n <= !ae_hit(32'(occ_nxt), 32'(ae_ofs));
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DW    = 18,
  parameter int DEPTH = 1024
) (
  input  logic                       wclk,
  input  logic                       rclk,
  input  logic                       rst_n,
  input  logic                       wr_en_n,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en_n,
  output logic [DW-1:0]              rd_data,
  input  logic                       rewind,
  input  logic [$clog2(DEPTH):0]     ae_ofs,
  input  logic [$clog2(DEPTH):0]     af_ofs,
  output logic                       empty_n,
  output logic                       aempty_n,
  output logic                       half_n,
  output logic                       afull_n,
  output logic                       full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // internal events brought out for the checker
  logic          wr_fire, rd_fire;
  logic [PW-1:0] wr_ptr, rd_ptr, wr_occ;
  logic [PW-1:0] wgray, rgray, wptr_seen, rptr_seen;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_q;

  xfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  xfifo_wctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wctl (
    .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .af_ofs(af_ofs),
    .rptr_seen(rptr_seen), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .wptr(wr_ptr), .wocc(wr_occ), .full_n(full_n), .afull_n(afull_n),
    .half_n(half_n)
  );

  xfifo_rctl #(.DW(DW), .AW(AW), .PW(PW)) u_rctl (
    .rclk(rclk), .rst_n(rst_n), .rd_en_n(rd_en_n), .rewind(rewind),
    .ae_ofs(ae_ofs), .wptr_seen(wptr_seen), .mem_q(mem_q), .rd_fire(rd_fire),
    .raddr(raddr), .rgray(rgray), .rptr(rd_ptr), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  xfifo_gsync #(.PW(PW)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wptr_seen)
  );

  xfifo_gsync #(.PW(PW)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rptr_seen)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int DW    = 18,
  parameter int DEPTH = 1024,
  parameter int PW    = 11
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          rewind,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic          full_n,
  input logic          afull_n,
  input logic          half_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_occ,
  input logic [DW-1:0] rd_data
);
  // R1
  no_write_when_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wr_ptr));

  // R1
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_occ <= PW'(DEPTH));

  // R2
  no_read_when_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && !rewind) |=> ($stable(rd_ptr) && $stable(rd_data)));

  // R2
  idle_read_holds_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_fire && !rewind) |=> $stable(rd_data));

  // R4
  empty_implies_aempty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  // R6
  full_implies_afull_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> (!afull_n && !half_n));

  // R1
  write_advances_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_fire |=> (wr_ptr == $past(wr_ptr) + PW'(1)));

  // R9
  rewind_to_zero_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rewind |=> (rd_ptr == '0));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rewind(rewind),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .full_n(full_n), .afull_n(afull_n),
  .half_n(half_n), .empty_n(empty_n), .aempty_n(aempty_n), .wr_ptr(wr_ptr),
  .rd_ptr(rd_ptr), .wr_occ(wr_occ), .rd_data(rd_data)
);

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DW    = 18;
  localparam int DEPTH = 16;
  localparam int PW    = 5;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1, rewind = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [PW-1:0] ae_ofs = 5'd3, af_ofs = 5'd2;
  logic empty_n, aempty_n, half_n, afull_n, full_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] hist[$];
  int rd_idx = 0;
  logic [DW-1:0] lastv = '0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  xclk_fifo #(.DW(DW), .DEPTH(DEPTH)) u_xclk_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n),
    .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_data(rd_data), .rewind(rewind),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .empty_n(empty_n), .aempty_n(aempty_n),
    .half_n(half_n), .afull_n(afull_n), .full_n(full_n)
  );

  function automatic int occ();
    return hist.size() - rd_idx;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int n, input int m);
    rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; rewind = 1'b0;
    ae_ofs = PW'(n); af_ofs = PW'(m);
    hist.delete(); rd_idx = 0; lastv = '0;
    repeat (3) @(negedge wclk);
    #0.5 rst_n = 1'b1;
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    @(negedge rclk);
  endtask

  task automatic check_flags(input string req);
    int c;
    c = occ();
    check(empty_n  == (c != 0), req, "empty_n", empty_n, c != 0);
    check(aempty_n == (c > int'(ae_ofs)), req, "aempty_n", aempty_n, c > int'(ae_ofs));
    check(half_n   == !(c > DEPTH/2), req, "half_n", half_n, !(c > DEPTH/2));
    check(afull_n  == ((c + int'(af_ofs)) < DEPTH), req, "afull_n", afull_n,
          (c + int'(af_ofs)) < DEPTH);
    check(full_n   == (c != DEPTH), req, "full_n", full_n, c != DEPTH);
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    logic f;
    @(negedge wclk);
    wr_en_n = 1'b0; wr_data = d; f = full_n;
    @(posedge wclk);
    if (f) hist.push_back(d);
    @(negedge wclk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd_word(input string req);
    logic e;
    @(negedge rclk);
    rd_en_n = 1'b0; e = empty_n;
    @(posedge rclk);
    @(negedge rclk);
    rd_en_n = 1'b1;
    if (e) begin
      check(rd_data == hist[rd_idx], req, "read word", rd_data, hist[rd_idx]);
      lastv = hist[rd_idx];
      rd_idx++;
    end else begin
      check(rd_data == lastv, req, "held word on empty", rd_data, lastv);
    end
  endtask

  task automatic rand_phase(input int iters, input int pw, input int pr);
    fork
      begin
        for (int i = 0; i < iters; i++) begin
          logic we, f;
          logic [DW-1:0] d;
          @(negedge wclk);
          check(!(full_n && occ() >= DEPTH), "R1", "full_n high at depth", occ(), DEPTH - 1);
          we = ($urandom % 100) < pw;
          d = DW'($urandom);
          wr_en_n = !we; wr_data = d; f = full_n;
          @(posedge wclk);
          if (we && f) hist.push_back(d);
        end
        @(negedge wclk) wr_en_n = 1'b1;
      end
      begin
        logic pend = 1'b0;
        logic [DW-1:0] expv = '0;
        for (int i = 0; i < iters; i++) begin
          logic re, e;
          @(negedge rclk);
          if (pend) check(rd_data == expv, "R8", "random read order", rd_data, expv);
          else check(rd_data == lastv, "R2", "hold without read", rd_data, lastv);
          check(!(empty_n && occ() == 0), "R4", "empty_n high at zero", occ(), 1);
          re = ($urandom % 100) < pr;
          rd_en_n = !re; e = empty_n;
          @(posedge rclk);
          pend = re && e;
          if (pend) begin
            expv = hist[rd_idx]; lastv = expv; rd_idx++;
          end
        end
        @(negedge rclk);
        if (pend) check(rd_data == expv, "R8", "random read order", rd_data, expv);
        rd_en_n = 1'b1;
      end
    join
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));

    // R7: reset state, sampled while reset is held
    rst_n = 1'b0;
    #(CLK_PERIOD * 2 + 0.5);
    check(rd_data == '0, "R7", "rd_data", rd_data, 0);
    check(empty_n == 1'b0 && aempty_n == 1'b0, "R7", "empty/aempty low",
          {empty_n, aempty_n}, 0);
    check(half_n && afull_n && full_n, "R7", "half/afull/full high",
          {half_n, afull_n, full_n}, 7);

    // R4 R5 R6: sweep occupancy 0..DEPTH and back with n=3 m=2
    do_reset(3, 2);
    settle();
    check_flags("R4");
    for (int k = 1; k <= DEPTH; k++) begin
      wr_word(DW'(k * 7 + 1));
      settle();
      check_flags(k > DEPTH/2 ? "R6" : "R5");
    end
    // R1: writes while full are dropped
    wr_word(18'h3ffff);
    wr_word(18'h2aaaa);
    settle();
    check(occ() == DEPTH, "R1", "accepted count", occ(), DEPTH);
    check_flags("R1");
    for (int k = 0; k < DEPTH; k++) begin
      rd_word("R1");
      settle();
      check_flags("R4");
    end
    // R2: reads on an empty buffer keep the last word
    rd_word("R2");
    rd_word("R2");
    check(rd_data == lastv, "R2", "last word kept", rd_data, lastv);

    // R4 R6: zero offsets make almost flags follow empty and full
    do_reset(0, 0);
    settle();
    check_flags("R4");
    wr_word(18'h00011);
    settle();
    check_flags("R4");
    for (int k = 1; k < DEPTH; k++) wr_word(DW'(k));
    settle();
    check_flags("R6");
    for (int k = 0; k < DEPTH; k++) rd_word("R8");

    // R3: first word latency with read enable held low
    do_reset(3, 2);
    @(negedge rclk) rd_en_n = 1'b0;
    wr_word(18'h1beef);
    while (!empty_n) @(negedge rclk);
    check(rd_data == '0, "R3", "not yet on output", rd_data, 0);
    @(negedge rclk);
    check(rd_data == 18'h1beef, "R3", "first word", rd_data, 18'h1beef);
    rd_en_n = 1'b1;
    lastv = hist[0]; rd_idx = 1;
    repeat (3) @(negedge rclk);
    check(rd_data == 18'h1beef, "R2", "hold after drain", rd_data, 18'h1beef);

    // R9 R10: rewind replay
    do_reset(3, 2);
    for (int k = 0; k < 5; k++) wr_word(DW'(18'h100 + k));
    for (int k = 0; k < 3; k++) rd_word("R9");
    settle();
    check_flags("R10");
    @(negedge rclk) rewind = 1'b1;
    @(negedge rclk) rewind = 1'b0;
    rd_idx = 0;
    settle();
    check_flags("R10");
    for (int k = 0; k < 5; k++) rd_word("R9");
    wr_word(18'h2c0de);
    settle();
    rd_word("R9");
    check(rd_data == 18'h2c0de, "R9", "post-rewind write", rd_data, 18'h2c0de);

    // R8: random traffic, writer-heavy then reader-heavy
    do_reset(4, 4);
    rand_phase(600, 75, 35);
    rand_phase(600, 30, 80);
    while (occ() > 0) rd_word("R8");
    settle();
    check_flags("R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule